// File: doc/BRIEF.md
# Fixed-Point Mandelbrot Iteration Engine

This block is a small accelerator with four memory-mapped registers. It runs the escape-time iteration Z = Z^2 + C for one point of the complex plane. Software writes the real and imaginary parts of C as signed 16-bit fixed-point numbers, with 6 integer bits and 10 fraction bits. It then sets the start bit in the control register. The engine raises busy, carries out one iteration per clock cycle starting from Z = 0, and stops when |Z|^2 goes above 4.0 or when the iteration count reaches its maximum. The escape count is returned in the low 4 bits of the result register.

Reads are combinational from the selected register. Writes take effect on the clock edge. While the engine is busy it ignores writes to the coordinate registers and to the start bit, so a running computation cannot be disturbed.

Top module: `mandel_engine`

## Requirements
- R1: After reset, the real, imaginary and result registers read 0 and the busy bit reads 0.
- R2: The address map is: 0 for the real part of C, 1 for the imaginary part of C, 2 for control, 3 for the result. The real and imaginary registers read back the 16-bit value last written to them while the engine was idle. The result register reads the 4-bit count in bits 3:0 and zeros above.
- R3: A write to address 2 with bit 1 set, while the engine is idle, sets busy in bit 0 of the control read from the next cycle. A write to address 2 with bit 1 clear does not start the engine. Control bits other than bit 0 read as 0.
- R4: Arithmetic is signed 6.10 fixed point and Z starts at 0. The next real part is ((re*re - im*im) >>> 10) + Cre. The next imaginary part is ((re*im) >>> 9) + Cim. Both are wrapped to 16 bits.
- R5: At iteration k (k = 0 for Z = 0), the engine escapes with result k if re*re + im*im > 4194304. That is the full-precision product sum above 4.0, computed wide enough that it cannot wrap. If iteration 15 is reached without escaping, the result is 15.
- R6: The engine performs one iteration per cycle, so busy reads 1 for exactly result+1 cycles after the start write.
- R7: While busy, writes to addresses 0, 1 and 2 have no effect. The result register keeps its previous value until the run completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | 2 | Register select |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data of the addressed register |

## Verification
The bench targets the following corner cases:
- Points whose magnitude sits exactly on 4.0, such as C = -2. A design using >= instead of > in the escape test would report 1 for this point instead of 15.
- Operands at the edge of the range, such as -32.0 and +31.999. A narrow magnitude sum would wrap here and report no escape.
- Bounded orbits, which must stop at 15. A counter that does not stop would wrap back to 0.
- Busy-cycle counts, which would show an extra or missing pipeline stage.
- Writes and restarts issued in the middle of a run. A design that does not block them would give a different result or corrupt the coordinate it reads back.

// File: rtl/mandel_engine.sv
module mandel_engine #(
  parameter int W    = 16,
  parameter int FRAC = 10,
  parameter int CW   = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata
);
  localparam int PW = 2*W + 2;
  localparam logic [CW-1:0] MAX_IT = '1;
  localparam logic signed [PW-1:0] LIMIT = PW'(4) <<< (2*FRAC);

  logic signed [W-1:0] c_re, c_im, z_re, z_im;
  logic [CW-1:0] it_cnt, result;
  logic busy;

  logic signed [PW-1:0] zr_x, zi_x, cr_x, ci_x, p_rr, p_ii, p_ri, mag;
  assign zr_x = {{(PW-W){z_re[W-1]}}, z_re};
  assign zi_x = {{(PW-W){z_im[W-1]}}, z_im};
  assign cr_x = {{(PW-W){c_re[W-1]}}, c_re};
  assign ci_x = {{(PW-W){c_im[W-1]}}, c_im};
  assign p_rr = zr_x * zr_x;
  assign p_ii = zi_x * zi_x;
  assign p_ri = zr_x * zi_x;
  assign mag  = p_rr + p_ii;

  logic escape, stop, start;
  logic signed [PW-1:0] nr_w, ni_w;
  assign escape = mag > LIMIT;
  assign stop   = escape || (it_cnt == MAX_IT);
  assign nr_w   = ((p_rr - p_ii) >>> FRAC) + cr_x;
  assign ni_w   = (p_ri >>> (FRAC-1)) + ci_x;
  assign start  = wr_en && !busy && (addr == 2'd2) && wdata[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_re <= '0; c_im <= '0; z_re <= '0; z_im <= '0;
      it_cnt <= '0; result <= '0; busy <= 1'b0;
    end else if (busy) begin
      if (stop) begin
        busy   <= 1'b0;
        result <= it_cnt;
      end else begin
        z_re   <= nr_w[W-1:0];
        z_im   <= ni_w[W-1:0];
        it_cnt <= it_cnt + 1'b1;
      end
    end else begin
      if (wr_en && addr == 2'd0) c_re <= wdata;
      if (wr_en && addr == 2'd1) c_im <= wdata;
      if (start) begin
        busy <= 1'b1; z_re <= '0; z_im <= '0; it_cnt <= '0;
      end
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = c_re;
      2'd1:    rdata = c_im;
      2'd2:    rdata = {{(W-1){1'b0}}, busy};
      default: rdata = {{(W-CW){1'b0}}, result};
    endcase
  end

  assert_busy_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_en && addr == 2'd2 && wdata[1]));
  assert_one_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> it_cnt == $past(it_cnt) + 1'b1);
  assert_inputs_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> ($stable(c_re) && $stable(c_im)));
  assert_result_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy -> $stable(result)));
  assert_final_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> result == $past(it_cnt));
  assert_count_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && it_cnt == MAX_IT) |=> !busy);
endmodule

// File: tb/mandel_engine_bench.sv
module mandel_engine_bench;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [1:0] addr = 0;
  logic [15:0] wdata = 0, rdata;
  int checks = 0, fails = 0;

  mandel_engine u_mandel_engine (.clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata));

  always #5 clk = ~clk;

  function automatic int model(int cr, int ci);
    longint zr = 0, zi = 0, nr, ni;
    for (int k = 0; k < 16; k++) begin
      if (zr*zr + zi*zi > 64'd4194304) return k;
      if (k == 15) return 15;
      nr = ((zr*zr - zi*zi) >>> 10) + cr;
      ni = ((zr*zi) >>> 9) + ci;
      zr = longint'(shortint'(nr));
      zi = longint'(shortint'(ni));
    end
    return 15;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(posedge clk); #1 wr_en = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic busy_cycles(output int n);
    n = 0; addr = 2;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (rdata[0]) n++; else break;
    end
  endtask

  task automatic run(logic [15:0] cr, logic [15:0] ci);
    int n, e;
    logic [15:0] d;
    e = model(int'($signed(cr)), int'($signed(ci)));
    wr(0, cr); wr(1, ci); wr(2, 16'h0002);
    busy_cycles(n);
    check("R6 busy cycles", n, e + 1);
    rd(3, d);
    check("R5/R4 result", int'(d), e);
    rd(0, d); check("R2 real readback", int'(d), int'(cr));
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] d;
    int n;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    rd(0, d); check("R1 real reset", int'(d), 0);
    rd(1, d); check("R1 imag reset", int'(d), 0);
    rd(2, d); check("R1 busy reset", int'(d), 0);
    rd(3, d); check("R1 result reset", int'(d), 0);

    wr(1, 16'h1234); rd(1, d); check("R2 imag readback", int'(d), 'h1234);
    wr(2, 16'h0001); rd(2, d); check("R3 no start without bit1", int'(d), 0);
    rd(3, d); check("R3 result untouched", int'(d), 0);

    run(16'h0000, 16'h0000);
    run(16'h0A00, 16'h0000);
    run(16'hF800, 16'h0000);
    run(16'h1FFF, 16'h1FFF);
    run(16'h8000, 16'h8000);
    run(16'hFC00, 16'h0400);
    run(16'h0100, 16'h0300);
    run(16'h0000, 16'h0800);

    wr(0, 16'h0A00); wr(1, 16'h0000); wr(2, 16'h0002);
    busy_cycles(n);
    rd(3, d); check("R7 prior result", int'(d), 1);
    wr(0, 16'hF800); wr(1, 16'h0000); wr(2, 16'h0002);
    rd(2, d); check("R3 busy bit", int'(d), 1);
    wr(0, 16'h0A00); wr(1, 16'h0123); wr(2, 16'h0002);
    rd(3, d); check("R7 result held while busy", int'(d), 1);
    busy_cycles(n);
    rd(3, d); check("R7 run undisturbed", int'(d), 15);
    rd(0, d); check("R7 real write ignored", int'(d), 'hF800);
    rd(1, d); check("R7 imag write ignored", int'(d), 0);

    for (int i = 0; i < 40; i++) begin
      logic [15:0] cr, ci;
      if (i % 4 == 0) begin
        cr = 16'($urandom); ci = 16'($urandom);
      end else begin
        cr = 16'(int'($urandom_range(0, 5120)) - 2560);
        ci = 16'(int'($urandom_range(0, 4096)) - 2048);
      end
      run(cr, ci);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule